// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block drives the read side of a synchronous burst flash store. A start strobe carries a starting word address. After a fixed initial latency, the block issues one word address per clock, one per data beat, to an external read port. It also drives a ready line whose timing and polarity are set by an 8-bit configuration register.

Bursts run in one of four modes, chosen by the length field:

- **Continuous:** the address keeps counting up, rolling from all-ones back to zero, until a terminate request arrives.
- **Linear, 8, 16 or 32 words:** with wrapping on, the address stays inside the aligned window that holds the start address and circles back to the window's first word. With wrapping off, the burst produces N consecutive addresses and may cross the window edge.

A terminate input cancels a burst at any point, including during the latency. The register also holds a clock-edge select bit. The block only stores that bit and reports it on the read-back port.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, the configuration read-back is 8'hF8. Its layout is: bit 7 ready polarity (1 = active high), bit 6 ready timing (1 = with data, 0 = one cycle early), bit 5 clock-edge select (1 = rising), bit 4 sequential order, bit 3 wrap enable, bits 2:0 length code. After reset the length code is 000 (continuous) and the block is idle with no beat.
- R2: A configuration write takes bits 7, 6, 5 and 3 as written. Bit 4 always reads 1. The length field changes only when the written code is legal (000 continuous, 010 eight, 011 sixteen, 100 thirty-two); any other code leaves it unchanged. The clock-edge bit is stored and read back only.
- R3: A start is accepted only when the block is idle and terminate is low. The first beat appears LAT cycles after the accepting edge, and no beat is issued before it. Beats then follow on consecutive cycles.
- R4: In continuous mode, each beat address is the previous one plus one, modulo 2^AW. The burst lasts until it is terminated.
- R5: In a linear mode with wrap enabled, the block issues exactly N beats. Each address is (start with its low log2(N) bits cleared) plus ((start + i) mod N), for beat i = 0 to N-1.
- R6: In a linear mode with wrap disabled, the block issues exactly N beats at start + i, modulo 2^AW, and these may cross the N-word boundary. The block then returns to idle.
- R7: With ready timing 1, the active ready level is present in exactly the cycles that carry a beat.
- R8: With ready timing 0, ready is active in the cycle before each beat. It is therefore active in the last latency cycle and in every beat cycle except the last beat of a linear burst.
- R9: With polarity 0, the ready output is the inverse of the active-high ready indication.
- R10: A terminate request sampled while busy returns the block to idle on the next cycle, with no further beats. A start strobe seen while busy is ignored.
- R11: The length and wrap settings are captured when a start is accepted. Configuration writes made during a burst do not change that burst's addresses or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read-back |
| start_i | input | 1 | Burst start strobe |
| start_addr_i | input | AW | Starting word address |
| term_i | input | 1 | Burst terminate request |
| addr_o | output | AW | Word address of the current beat, zero when no beat |
| beat_valid_o | output | 1 | A beat address is present this cycle |
| rdy_o | output | 1 | Ready indication, with configured timing and polarity |
| busy_o | output | 1 | A burst is in latency or in progress |

## Verification
The assertions assume that start, terminate and configuration inputs change only between clock edges and are held for whole cycles. They also assume that LAT is at least 2, so the early ready has a latency cycle to sit in. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It deliberately overlaps requests: start together with terminate, start during a burst, and configuration writes during a burst. Every one of these overlaps is a case the requirements define.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int CFG_W   = 8;
  localparam int MAX_LEN = 32;
  localparam int CNT_W   = $clog2(MAX_LEN);

  localparam logic [2:0] LEN_CONT = 3'b000;
  localparam logic [2:0] LEN_8    = 3'b010;
  localparam logic [2:0] LEN_16   = 3'b011;
  localparam logic [2:0] LEN_32   = 3'b100;

  typedef struct packed {
    logic       rdy_high;
    logic       rdy_same;
    logic       edge_rise;
    logic       seq_order;
    logic       wrap_en;
    logic [2:0] len;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{rdy_high: 1'b1, rdy_same: 1'b1, edge_rise: 1'b1,
                                 seq_order: 1'b1, wrap_en: 1'b1, len: LEN_CONT};

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BEAT} st_e;

  function automatic logic len_legal(input logic [2:0] code);
    return (code == LEN_CONT) || (code == LEN_8) || (code == LEN_16) || (code == LEN_32);
  endfunction

  // index of the final beat of a linear burst; zero for continuous
  function automatic logic [CNT_W-1:0] len_last(input logic [2:0] code);
    unique case (code)
      LEN_8:   return CNT_W'(7);
      LEN_16:  return CNT_W'(15);
      LEN_32:  return CNT_W'(31);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);

  cfg_t cfg_q;
  cfg_t wr;

  assign wr = cfg_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RESET;
    end else if (we_i) begin
      cfg_q.rdy_high  <= wr.rdy_high;
      cfg_q.rdy_same  <= wr.rdy_same;
      cfg_q.edge_rise <= wr.edge_rise;
      cfg_q.seq_order <= 1'b1;
      cfg_q.wrap_en   <= wr.wrap_en;
      if (len_legal(wr.len)) cfg_q.len <= wr.len;
    end
  end

  assign cfg_o = cfg_q;

  assert_len_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !len_legal(wr.len)) |=> (cfg_q.len == $past(cfg_q.len)));

  assert_len_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && len_legal(wr.len)) |=> (cfg_q.len == $past(wr.len)));

endmodule

// File: rtl/burst_step.sv
module burst_step
  import burst_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur_i,
  input  logic [2:0]    len_i,
  input  logic          wrap_i,
  output logic [AW-1:0] next_o
);

  logic [AW-1:0] win_mask;
  logic [AW-1:0] inc;

  assign win_mask = AW'(len_last(len_i));
  assign inc      = cur_i + 1'b1;

  always_comb begin
    if (wrap_i && (len_i != LEN_CONT)) next_o = (cur_i & ~win_mask) | (inc & win_mask);
    else                               next_o = inc;
  end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int LAT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          term_i,
  input  logic [2:0]    len_i,
  input  logic          wrap_i,
  output logic [AW-1:0] addr_o,
  output logic          beat_o,
  output logic          pre_beat_o,
  output logic          busy_o
);

  localparam int LW = $clog2(LAT + 1);

  st_e              st_q;
  logic [LW-1:0]    lat_q;
  logic [AW-1:0]    addr_q, addr_nx;
  logic [2:0]       len_q;
  logic             wrap_q;
  logic [CNT_W-1:0] cnt_q, last_idx;
  logic             linear, last_beat, accept;
  logic [AW-1:0]    win_mask;

  assign linear    = (len_q != LEN_CONT);
  assign last_idx  = len_last(len_q);
  assign last_beat = linear && (cnt_q == last_idx);
  assign accept    = (st_q == ST_IDLE) && start_i && !term_i;
  assign win_mask  = AW'(last_idx);

  burst_step #(.AW(AW)) u_step (
    .cur_i (addr_q),
    .len_i (len_q),
    .wrap_i(wrap_q),
    .next_o(addr_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      lat_q  <= '0;
      addr_q <= '0;
      len_q  <= LEN_CONT;
      wrap_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q   <= ST_WAIT;
            lat_q  <= LW'(LAT);
            addr_q <= start_addr_i;
            len_q  <= len_i;
            wrap_q <= wrap_i;
            cnt_q  <= '0;
          end
        end
        ST_WAIT: begin
          if (term_i) begin
            st_q <= ST_IDLE;
          end else begin
            lat_q <= lat_q - 1'b1;
            if (lat_q == LW'(1)) st_q <= ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (term_i || last_beat) begin
            st_q <= ST_IDLE;
          end else begin
            addr_q <= addr_nx;
            cnt_q  <= cnt_q + 1'b1;  // free-running in continuous mode, unused there
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign beat_o     = (st_q == ST_BEAT);
  assign busy_o     = (st_q != ST_IDLE);
  assign addr_o     = beat_o ? addr_q : '0;
  // a beat follows next cycle unless terminated
  assign pre_beat_o = ((st_q == ST_WAIT) && (lat_q == LW'(1))) || (beat_o && !last_beat);

  initial assert (LAT >= 2) else $error("LAT must be at least 2");

  assert_latency_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (busy_o && !beat_o));

  assert_cont_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && !linear && !term_i) |=> (beat_o && (addr_o == $past(addr_o) + 1'b1)));

  assert_linear_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && linear) |-> (cnt_q <= last_idx));

  assert_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && linear && wrap_q && !term_i && !last_beat) |=>
      ((addr_o & ~win_mask) == $past(addr_o & ~win_mask)));

  assert_term_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && term_i) |=> !busy_o);

endmodule

// File: rtl/burst_rdy.sv
module burst_rdy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beat_i,
  input  logic pre_beat_i,
  input  logic term_i,
  input  logic same_i,
  input  logic high_i,
  output logic rdy_o
);

  logic act;

  assign act   = same_i ? beat_i : pre_beat_i;
  assign rdy_o = high_i ? act : ~act;

  assert_early_lead_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_beat_i && !term_i) |=> beat_i);

  assert_same_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beat_i && same_i) |-> (rdy_o == ~high_i));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int LAT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [7:0]    cfg_wdata_i,
  output logic [7:0]    cfg_rdata_o,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          term_i,
  output logic [AW-1:0] addr_o,
  output logic          beat_valid_o,
  output logic          rdy_o,
  output logic          busy_o
);

  cfg_t cfg;
  logic pre_beat;

  burst_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg)
  );

  burst_ctrl #(.AW(AW), .LAT(LAT)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_addr_i(start_addr_i),
    .term_i      (term_i),
    .len_i       (cfg.len),
    .wrap_i      (cfg.wrap_en),
    .addr_o      (addr_o),
    .beat_o      (beat_valid_o),
    .pre_beat_o  (pre_beat),
    .busy_o      (busy_o)
  );

  burst_rdy u_rdy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (beat_valid_o),
    .pre_beat_i(pre_beat),
    .term_i    (term_i),
    .same_i    (cfg.rdy_same),
    .high_i    (cfg.rdy_high),
    .rdy_o     (rdy_o)
  );

  assign cfg_rdata_o = cfg;

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  localparam int AW     = 16;
  localparam int LAT    = 4;
  localparam int CLK_NS = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          term = 1'b0;
  logic [AW-1:0] addr;
  logic          beat_valid, rdy, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string scen_tag = "";

  always #(CLK_NS/2) clk = ~clk;

  burst_addr_seq #(.AW(AW), .LAT(LAT)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata),
    .start_i     (start),
    .start_addr_i(start_addr),
    .term_i      (term),
    .addr_o      (addr),
    .beat_valid_o(beat_valid),
    .rdy_o       (rdy),
    .busy_o      (busy)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]    m_cfg;
  int            m_lat;
  bit            m_act;
  bit            m_cont;
  string         m_tag;
  logic [AW-1:0] q[$];

  function automatic bit legal(input logic [2:0] c);
    return c == 3'b000 || c == 3'b010 || c == 3'b011 || c == 3'b100;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 8'hF8; m_lat = 0; m_act = 0; m_cont = 0; m_tag = "R4"; q.delete();
    end else begin
      if (m_act) begin
        if (term) begin
          m_act = 0; q.delete();
        end else begin
          logic [AW-1:0] a;
          a = q.pop_front();
          if (m_cont) q.push_back(a + 1'b1);
          if (q.size() == 0) m_act = 0;
        end
      end else if (m_lat > 0) begin
        if (term) begin
          m_lat = 0; q.delete();
        end else begin
          m_lat--;
          if (m_lat == 0) m_act = 1;
        end
      end else if (start && !term) begin
        int n;
        n = (m_cfg[2:0] == 3'b010) ? 8 : (m_cfg[2:0] == 3'b011) ? 16 :
            (m_cfg[2:0] == 3'b100) ? 32 : 0;
        m_cont = (n == 0);
        m_lat  = LAT;
        q.delete();
        if (m_cont) begin
          m_tag = "R4";
          q.push_back(start_addr);
        end else if (m_cfg[3]) begin
          logic [AW-1:0] base;
          m_tag = "R5";
          base = start_addr & ~AW'(n - 1);
          for (int i = 0; i < n; i++) q.push_back(base | AW'((int'(start_addr) + i) % n));
        end else begin
          m_tag = "R6";
          for (int i = 0; i < n; i++) q.push_back(start_addr + AW'(i));
        end
      end
      if (cfg_we)
        m_cfg = {cfg_wdata[7:5], 1'b1, cfg_wdata[3],
                 legal(cfg_wdata[2:0]) ? cfg_wdata[2:0] : m_cfg[2:0]};
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [AW-1:0] e_addr;
      bit e_pre, e_act, e_rdy;
      string rtag;
      e_addr = m_act ? q[0] : '0;
      e_pre  = (m_lat == 1) || (m_act && (m_cont || q.size() > 1));
      e_act  = m_cfg[6] ? m_act : e_pre;
      e_rdy  = m_cfg[7] ? e_act : !e_act;
      rtag   = !m_cfg[7] ? "R9" : (m_cfg[6] ? "R7" : "R8");
      check(cfg_rdata == m_cfg, "R2", cfg_rdata, m_cfg);
      check(busy == (m_act || m_lat > 0), "R10", busy, (m_act || m_lat > 0));
      check(beat_valid == m_act, "R3", beat_valid, m_act);
      check(addr == e_addr, (scen_tag != "") ? scen_tag : m_tag, addr, e_addr);
      check(rdy == e_rdy, rtag, rdy, e_rdy);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic go(input logic [AW-1:0] a);
    start = 1'b1; start_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // R1: reset state
    check(cfg_rdata == 8'hF8, "R1", cfg_rdata, 8'hF8);
    check(!busy && !beat_valid && !rdy, "R1", {busy, beat_valid, rdy}, 3'b000);
    cyc(2);

    // R4: continuous with rollover past all-ones
    go(16'hFFFD);
    cyc(LAT + 6);
    term = 1'b1; cyc(1); term = 1'b0;
    cyc(2);

    // R5: wrapped linear bursts of each length
    wr(8'hFA); go(16'h0105); wait_idle(); cyc(1);
    wr(8'hFB); go(16'h023B); wait_idle(); cyc(1);
    wr(8'hFC); go(16'h0411); wait_idle(); cyc(1);

    // R6: non-wrapping linear burst crossing the window edge
    wr(8'hF2); go(16'h0106); wait_idle(); cyc(1);
    wr(8'hF4); go(16'hFFF0); wait_idle(); cyc(1);

    // R8: early ready
    wr(8'hB2); go(16'h0010); wait_idle(); cyc(1);
    // R9: inverted ready, early then same-cycle
    wr(8'h3A); go(16'h0020); wait_idle(); cyc(1);
    wr(8'h7B); go(16'h0033); wait_idle(); cyc(1);

    // R2: illegal length codes leave the length; sequential bit sticks at 1
    wr(8'hD9);
    check(cfg_rdata == 8'hDB, "R2", cfg_rdata, 8'hDB);
    wr(8'hEF);
    check(cfg_rdata == 8'hFB, "R2", cfg_rdata, 8'hFB);

    // R11: writes during a burst keep its length and wrap
    scen_tag = "R11";
    go(16'h0300);
    cyc(LAT + 2);
    wr(8'hF8);
    // R10: start while busy is ignored
    go(16'h7777);
    wait_idle();
    scen_tag = "";
    cyc(1);

    // R10: terminate during latency, start together with terminate
    wr(8'hFA);
    go(16'h0400);
    cyc(1);
    term = 1'b1; cyc(1); term = 1'b0;
    check(!busy, "R10", busy, 0);
    start = 1'b1; term = 1'b1; start_addr = 16'h0500;
    cyc(1);
    start = 1'b0; term = 1'b0;
    check(!busy, "R3", busy, 0);
    // terminate mid linear burst
    go(16'h0600);
    cyc(LAT + 2);
    term = 1'b1; cyc(1); term = 1'b0;
    check(!beat_valid, "R10", beat_valid, 0);
    cyc(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired (R3) actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule